// File: doc/BRIEF.md
# Per-Channel Event Framer with Length Guard

The framer sits behind one digitized readout input. It turns a loosely timed stream of sample words, bracketed by begin and finish markers, into self-contained blocks for a downstream FIFO. Each block is a header word carrying the event number, then the payload samples, then a trailer word. The trailer holds the count of payload words actually stored, plus two status flags.

Events come at irregular times and vary in length. A programmable length ceiling caps each block. If a sample would go past the ceiling, the block is closed with a trailer straight away, and the rest of that event's samples are discarded. While the downstream FIFO signals almost full, the ceiling drops to a small fixed value. During that time a busy line is raised toward trigger control. An error record is produced for every block that was cut short or that saw the reduced ceiling.

Every output is registered, so each write, error record and busy change shows up one clock after the input cycle that caused it. The begin marker, a sample and the finish marker are expected in separate cycles.

Top module: `evt_framer`

## Requirements
- R1: A begin marker (`ev_start`) that arrives while no block is open writes a header word one cycle later. The header has tag bits [17:16] = 2'b10 and the event number zero-extended in bits [15:0].
- R2: Each sample that is accepted is written one cycle later as a payload word: tag 2'b01, with the sample in bits [15:0]. Samples keep their arrival order.
- R3: A finish marker (`ev_end`) on an open block writes a trailer one cycle later. The trailer has tag 2'b11, bit 15 = truncated, bit 14 = reduced, bits 13:10 = 0, and bits 9:0 = the number of payload words written.
- R4: A sample that arrives when the payload count already equals the active ceiling is not written. Instead, a trailer with bit 15 set is written one cycle later, and the block is closed.
- R5: Samples that arrive after a truncation are discarded, up to and including the event's finish marker, and nothing is written for them.
- R6: In any cycle with `fifo_afull` high, the active ceiling is the smaller of RED_LEN (default 8) and `max_len`. Otherwise the ceiling is `max_len`.
- R7: Trailer bit 14 is set when `fifo_afull` was high in any cycle from the begin cycle through the cycle that closes the block.
- R8: `busy` is high the cycle after any cycle with `fifo_afull` high. Once raised, it stays high while a block remains open, and it clears only after almost-full has dropped and the block has been closed.
- R9: `err_valid` pulses in the same cycle as any trailer that has bit 15 or bit 14 set. It carries `err_code` = {reduced, truncated} and the event number of that block.
- R10: An event with no samples gives a header followed by a trailer with count 0.
- R11: After reset there are no writes, no error records, and `busy` is low.
- R12: A begin marker while a block is open, and a sample or finish marker while idle, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | Begin-of-event marker |
| ev_num | input | 8 | Event number, taken with `ev_start` |
| smp_valid | input | 1 | Sample word present |
| smp_data | input | 16 | Sample word |
| ev_end | input | 1 | End-of-event marker |
| max_len | input | 10 | Normal payload ceiling |
| fifo_afull | input | 1 | Downstream FIFO almost full |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 18 | FIFO word: 2-bit tag plus 16-bit body |
| busy | output | 1 | Back-pressure toward trigger control |
| err_valid | output | 1 | Error record strobe |
| err_code | output | 2 | {reduced, truncated} |
| err_evnum | output | 8 | Event number of the flagged block |

## Verification
The bench aims at the ceiling boundary. A block of exactly `max_len` samples must close cleanly, and the next sample must truncate. An off-by-one there would either write one word too many or flag a clean block as cut.

It raises almost-full partway through events. A design that latched the ceiling at the begin marker, or forgot the reduced flag, would let oversized blocks through or leave bit 14 clear.

It checks that busy holds through an open block after almost-full has dropped, and that it clears only after the trailer.

It also sends stray markers and post-truncation samples. A design that honoured them would write extra words or a second trailer.

// File: rtl/evt_framer_pkg.sv
// Shared encodings for the event framer.
// Assumes nothing beyond the 2-bit tag that sits at the top of every FIFO word.
package evt_framer_pkg;
    // Tag carried in the top two bits of every FIFO word.
    typedef enum logic [1:0] {
        TAG_NONE = 2'b00,
        TAG_PAY  = 2'b01,
        TAG_HDR  = 2'b10,
        TAG_TRL  = 2'b11
    } tag_e;

    // Framing state of the channel.
    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_COLL = 2'b01,
        S_DROP = 2'b10
    } st_e;

    // Which word the output stage should produce this cycle.
    typedef enum logic [1:0] {
        W_NONE = 2'b00,
        W_HDR  = 2'b01,
        W_PAY  = 2'b10,
        W_TRL  = 2'b11
    } wsel_e;
endpackage

// File: rtl/evt_len_guard.sv
// Payload counter and ceiling selection.
// Assumes: clr and inc are never high together. The ceiling is re-evaluated
// every cycle, so an almost-full that arrives mid-event takes effect at once.
module evt_len_guard #(
    parameter int LW      = 10,
    parameter int RED_LEN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          afull,
    input  logic [LW-1:0] max_len,
    output logic [LW-1:0] cnt,
    output logic [LW-1:0] limit,
    output logic          room
);
    localparam logic [LW-1:0] RED = LW'(RED_LEN);

    // Pick the active ceiling: the reduced one only while almost-full is high.
    always_comb begin
        limit = (afull && (RED < max_len)) ? RED : max_len;
        room  = (cnt < limit);
    end

    // Count payload words written into the open block.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // The counter never steps past the ceiling that was in force when it stepped.
    p_cnt_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt <= $past(limit)));
endmodule

// File: rtl/evt_busy_ctl.sv
// Back-pressure flag toward trigger control.
// Assumes open_next is high when a block will still be open after this cycle.
module evt_busy_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic afull,
    input  logic open_next,
    output logic busy
);
    // Set on almost-full; hold while the current block stays open.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= 1'b0;
        else        busy <= afull | (busy & open_next);
    end

    p_busy_on_afull_r8: assert property (@(posedge clk) disable iff (!rst_n)
        afull |=> busy);
endmodule

// File: rtl/evt_word_fmt.sv
// Registered output stage: builds header, payload and trailer words.
// Assumes NW <= SW and LW <= SW-2, so every field fits in the body.
module evt_word_fmt
    import evt_framer_pkg::*;
#(
    parameter int SW = 16,
    parameter int NW = 8,
    parameter int LW = 10,
    localparam int DW = SW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wsel_e         wsel,
    input  logic [SW-1:0] smp_data,
    input  logic [NW-1:0] ev_num,
    input  logic [LW-1:0] cnt,
    input  logic          trunc,
    input  logic          red,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_data
);
    // Register the selected word and its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
        end else begin
            fifo_wr <= (wsel != W_NONE);
            unique case (wsel)
                W_HDR:   fifo_data <= {TAG_HDR, SW'(ev_num)};
                W_PAY:   fifo_data <= {TAG_PAY, smp_data};
                W_TRL:   fifo_data <= {TAG_TRL, trunc, red, (SW-2)'(cnt)};
                default: fifo_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/evt_framer.sv
// Per-channel event framer. Frames one readout input's events as
// header / payload / trailer, enforces a length ceiling, drops overflow,
// and reports almost-full reduction through busy and error records.
// Assumes ev_start, smp_valid and ev_end are mutually exclusive in a cycle.
module evt_framer
    import evt_framer_pkg::*;
#(
    parameter int SW      = 16,
    parameter int NW      = 8,
    parameter int LW      = 10,
    parameter int RED_LEN = 8,
    localparam int DW     = SW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_start,
    input  logic [NW-1:0] ev_num,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp_data,
    input  logic          ev_end,
    input  logic [LW-1:0] max_len,
    input  logic          fifo_afull,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_data,
    output logic          busy,
    output logic          err_valid,
    output logic [1:0]    err_code,
    output logic [NW-1:0] err_evnum
);
    st_e           st_q, st_n;
    wsel_e         wsel;
    logic          clr, inc, trunc, red_q, red_now;
    logic [LW-1:0] cnt, limit;
    logic          room;
    logic [NW-1:0] num_q;

    evt_len_guard #(.LW(LW), .RED_LEN(RED_LEN)) u_guard (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .afull(fifo_afull),
        .max_len(max_len), .cnt(cnt), .limit(limit), .room(room)
    );

    evt_busy_ctl u_busy (
        .clk(clk), .rst_n(rst_n), .afull(fifo_afull),
        .open_next(st_n == S_COLL), .busy(busy)
    );

    evt_word_fmt #(.SW(SW), .NW(NW), .LW(LW)) u_fmt (
        .clk(clk), .rst_n(rst_n), .wsel(wsel), .smp_data(smp_data),
        .ev_num(ev_num), .cnt(cnt), .trunc(trunc), .red(red_now),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data)
    );

    assign red_now = red_q | fifo_afull;

    // Framing decisions: next state, word to emit, counter control.
    always_comb begin
        st_n  = st_q;
        wsel  = W_NONE;
        clr   = 1'b0;
        inc   = 1'b0;
        trunc = 1'b0;
        unique case (st_q)
            S_IDLE: if (ev_start) begin
                st_n = S_COLL;
                wsel = W_HDR;
                clr  = 1'b1;
            end
            S_COLL: if (ev_end) begin
                st_n = S_IDLE;
                wsel = W_TRL;
            end else if (smp_valid) begin
                if (room) begin
                    wsel = W_PAY;
                    inc  = 1'b1;
                end else begin
                    wsel  = W_TRL;
                    trunc = 1'b1;
                    st_n  = S_DROP;
                end
            end
            S_DROP: if (ev_end) st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    // State, sticky reduced flag and event number of the open block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            red_q <= 1'b0;
            num_q <= '0;
        end else begin
            st_q <= st_n;
            if (st_q == S_IDLE && ev_start) begin
                red_q <= fifo_afull;
                num_q <= ev_num;
            end else if (st_q == S_COLL) begin
                red_q <= red_now;
            end
        end
    end

    // Error record issued alongside any flagged trailer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_code  <= 2'b00;
            err_evnum <= '0;
        end else begin
            err_valid <= (wsel == W_TRL) && (trunc || red_now);
            err_code  <= {red_now, trunc};
            err_evnum <= num_q;
        end
    end

    p_header_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && fifo_data[DW-1 -: 2] == TAG_HDR) |-> ($past(st_q) == S_IDLE));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && fifo_data[DW-1 -: 2] == TAG_PAY) |-> (cnt <= $past(limit)));

    p_drop_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DROP) |=> !fifo_wr);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_n == S_COLL) |=> busy);

    p_err_with_trailer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (fifo_wr && fifo_data[DW-1 -: 2] == TAG_TRL));
endmodule

// File: tb/evt_framer_bench.sv
`timescale 1ns/1ps
module evt_framer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_start = 0, smp_valid = 0, ev_end = 0, fifo_afull = 0;
    logic [7:0]  ev_num = 0;
    logic [15:0] smp_data = 0;
    logic [9:0]  max_len = 10;
    logic        fifo_wr, busy, err_valid;
    logic [17:0] fifo_data;
    logic [1:0]  err_code;
    logic [7:0]  err_evnum;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // reference model state
    int        m_st = 0, m_cnt = 0;
    bit        m_red = 0, m_busy = 0;
    logic [7:0] m_num = 0;

    always #4 clk = ~clk;

    evt_framer u_evt_framer (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_num(ev_num),
        .smp_valid(smp_valid), .smp_data(smp_data), .ev_end(ev_end),
        .max_len(max_len), .fifo_afull(fifo_afull), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .busy(busy), .err_valid(err_valid),
        .err_code(err_code), .err_evnum(err_evnum)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ceiling(input bit af, input int ml);
        return (af && ml > 8) ? 8 : ml;
    endfunction

    // Drive one cycle (called at a negedge), predict, and compare after the edge.
    task automatic step(input bit s, input bit v, input bit e, input bit af,
                        input logic [7:0] num, input logic [15:0] d);
        bit x_wr = 0, x_err = 0, x_tr = 0, red_now;
        logic [17:0] x_data = '0;
        logic [1:0]  x_code = 0;
        logic [7:0]  x_num = 0;
        string tag = "R2";
        ev_start = s; smp_valid = v; ev_end = e; fifo_afull = af;
        ev_num = num; smp_data = d;
        red_now = m_red | af;
        case (m_st)
            0: begin
                if (s) begin
                    x_wr = 1; x_data = {2'b10, 8'h00, num}; tag = "R1";
                    m_cnt = 0; m_red = af; m_num = num; m_st = 1;
                end else if (v || e) tag = "R12";
            end
            1: begin
                if (s) tag = "R12";
                if (e) begin
                    x_wr = 1; x_data = {2'b11, 1'b0, red_now, 4'h0, 10'(m_cnt)};
                    tag = (m_cnt == 0) ? "R10" : (red_now ? "R7" : "R3");
                    x_err = red_now; x_code = {red_now, 1'b0}; x_num = m_num;
                    m_st = 0;
                end else if (v) begin
                    if (m_cnt < ceiling(af, int'(max_len))) begin
                        x_wr = 1; x_data = {2'b01, d}; m_cnt++; m_red = red_now;
                    end else begin
                        x_tr = 1; x_wr = 1;
                        x_data = {2'b11, 1'b1, red_now, 4'h0, 10'(m_cnt)};
                        tag = (af && max_len > 8) ? "R6" : "R4";
                        x_err = 1; x_code = {red_now, 1'b1}; x_num = m_num;
                        m_st = 2;
                    end
                end else m_red = red_now;
            end
            default: begin
                tag = "R5";
                if (e) m_st = 0;
            end
        endcase
        m_busy = af | (m_busy & (m_st == 1));
        @(posedge clk); #1;
        chk(tag, 32'(fifo_wr), 32'(x_wr));
        if (x_wr) chk(tag, 32'(fifo_data), 32'(x_data));
        chk("R8", 32'(busy), 32'(m_busy));
        chk("R9", 32'(err_valid), 32'(x_err));
        if (x_err) chk("R9", {22'h0, err_code, err_evnum}, {22'h0, x_code, x_num});
        if (x_tr) chk("R4", 32'(fifo_data[15]), 32'd1);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit af);
        for (int i = 0; i < n; i++) step(0, 0, 0, af, 0, 0);
    endtask

    // A whole event of n samples with almost-full held at af.
    task automatic event_run(input logic [7:0] num, input int n, input bit af);
        step(1, 0, 0, af, num, 0);
        for (int i = 0; i < n; i++) step(0, 1, 0, af, 0, 16'(16'hA000 + i));
        step(0, 0, 1, af, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        // R11: reset state
        chk("R11", 32'(fifo_wr), 0);
        chk("R11", 32'(busy), 0);
        chk("R11", 32'(err_valid), 0);
        rst_n = 1;
        idle(2, 0);
        max_len = 10;
        event_run(8'h01, 0, 0);        // R10 empty event
        event_run(8'h02, 5, 0);        // R2/R3 normal
        event_run(8'h03, 10, 0);       // exactly at ceiling
        event_run(8'h04, 14, 0);       // R4/R5 truncation and drop
        step(0, 1, 0, 0, 0, 16'h1);    // R12 stray sample while idle
        step(0, 0, 1, 0, 0, 0);        // R12 stray finish while idle
        // R6/R7: almost-full mid-event with 12 samples
        step(1, 0, 0, 0, 8'h05, 0);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 16'(i));
        for (int i = 0; i < 8; i++) step(0, 1, 0, 1, 0, 16'(i + 4));
        step(0, 0, 1, 0, 0, 0);
        // R7/R8: short almost-full pulse, block open after it drops
        step(1, 0, 0, 0, 8'h06, 0);
        step(0, 1, 0, 1, 0, 16'h55);
        step(0, 1, 0, 0, 0, 16'h56);
        step(1, 0, 0, 0, 8'h99, 0);    // R12 stray begin while open
        idle(3, 0);
        step(0, 0, 1, 0, 0, 0);
        idle(2, 0);
        // random traffic
        for (int k = 0; k < 400; k++) begin
            bit af = ($urandom_range(0, 5) == 0);
            max_len = 10'($urandom_range(0, 15));
            idle($urandom_range(0, 2), af);
            step(1, 0, 0, af, 8'(k), 0);
            for (int j = 0; j < int'($urandom_range(0, 20)); j++) begin
                if ($urandom_range(0, 7) == 0) af = ~af;
                case ($urandom_range(0, 9))
                    0: step(0, 0, 0, af, 0, 0);
                    1: step(1, 0, 0, af, 8'hEE, 0);
                    default: step(0, 1, 0, af, 0, 16'($urandom));
                endcase
            end
            step(0, 0, 1, af, 0, 0);
        end
        idle(3, 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule